// File: doc/BRIEF.md
# Subcode Q Block Capture and DAT ID Detector

This block sits behind a digital audio receiver's frame demodulator. It takes in the user-data bit stream, one bit per strobe, with a marker on the first bit of each block. It collects a 96-bit subcode Q block, which is 80 payload bits followed by a 16-bit check word. It verifies the check word, then loads the payload and a pass/fail flag into a holding buffer, and announces the new contents with an active-low ready strobe. A serial read port elsewhere in the chip shifts the buffer out in index order, starting at index 0.

The block also watches the per-frame left and right user bits for the DAT marker patterns, but only while the channel-status category code reports a DAT source. In a sync frame the left bit is high. If the right bit of that same frame is high, the block has found a start marker. If instead the left bit of the next frame is high, the block has found a shortening marker. A detected marker overwrites the buffer with all ones (start) or all zeros (shortening) and fires the same ready strobe. While the receiver reports a lock error, the buffer outputs read as zero and any partly received block is thrown away.

Top module: `subq_capture`

## Requirements
- R1: A payload load and a ready pulse happen only after the 96th bit of a block that began with `blk_start_i` high. Bits that arrive before any block start are ignored. A new block start in the middle of a block restarts collection at bit 0.
- R2: The check word uses polynomial x^16+x^12+x^5+1 with a zero initial value, run over the 80 payload bits in arrival order. The 16 received check bits arrive MSB first and are stored inverted. `q_flag_o` is 1 when the received word equals the bitwise inverse of the computed value, and 0 otherwise.
- R3: Payload bytes arrive MSB first. Bit i of received byte b (b = 0..9, i = 0..7) appears on `q_data_o[8*b+i]`, so reading out from index 0 upward gives each byte LSB first.
- R4: Marker detection is active only while `cat_code_i[7:1]` equals 7'b1100000. `cat_code_i[0]` is ignored. With any other code, marker patterns leave the buffer and the ready strobe unchanged.
- R5: A frame with `user_l_i`=1 and `user_r_i`=1 is a start marker. The buffer becomes all ones, the flag becomes 1, and a ready pulse follows.
- R6: A frame with `user_l_i`=1 and `user_r_i`=0 arms the detector. If the next frame has `user_l_i`=1, that is a shortening marker: the buffer becomes all zeros, the flag becomes 0, and a ready pulse follows.
- R7: `rdy_no_o` goes low on the second clock edge after the completing bit or marker frame. It stays low for exactly PULSE_FRAMES (default 6) frame strobes, then returns high.
- R8: While `lock_err_i` is high, `q_data_o` and `q_flag_o` read 0, any active ready pulse ends, and the partly collected block is discarded. After the lock error clears, the previous buffer contents are visible again.
- R9: After reset, `rdy_no_o` is 1 and `q_data_o` and `q_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_err_i | input | 1 | Receiver lock error |
| bit_vld_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Subcode Q serial bit |
| blk_start_i | input | 1 | Marks the first bit of a 96-bit block |
| frame_stb_i | input | 1 | One pulse per audio frame |
| user_l_i | input | 1 | Left user bit of this frame |
| user_r_i | input | 1 | Right user bit of this frame |
| cat_code_i | input | 8 | Channel-status category code |
| q_data_o | output | 80 | Held payload or marker pattern |
| q_flag_o | output | 1 | Check pass flag or marker flag |
| rdy_no_o | output | 1 | Ready strobe, active low |

## Verification
The assertions assume the following about the inputs:
- `blk_start_i` is only meaningful together with `bit_vld_i`.
- `bit_vld_i` and `frame_stb_i` are single-cycle strobes.
- The category code is stable around each frame strobe.

The stimulus meets these assumptions. It sends each bit as a one-cycle strobe followed by an idle cycle. It raises the block marker only on the first bit of a block. It keeps frame strobes and bit strobes in separate cycles, and changes the category code only between frames.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned Q_DATA_BITS = 80;
  localparam int unsigned Q_CHK_BITS  = 16;
  localparam logic [15:0] CHK_POLY    = 16'h1021;
  localparam logic [6:0]  DAT_CAT     = 7'b1100000;
endpackage

// File: rtl/subq_crc16.sv
module subq_crc16 #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, base, nxt;

  always_comb begin
    base = init_i ? '0 : crc_q;
    nxt  = {base[W-2:0], 1'b0} ^ ((bit_i ^ base[W-1]) ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= nxt;
    else if (init_i) crc_q <= '0;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/subq_collect.sv
module subq_collect #(
  parameter int unsigned DATA_BITS = subq_pkg::Q_DATA_BITS,
  parameter int unsigned CHK_BITS  = subq_pkg::Q_CHK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic                 blk_start_i,
  output logic                 done_o,
  output logic                 pass_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int unsigned TOTAL = DATA_BITS + CHK_BITS;
  localparam int unsigned CW    = $clog2(TOTAL + 1);
  localparam int unsigned DIW   = $clog2(DATA_BITS);

  logic                 active_q, done_q, pass_q;
  logic [CW-1:0]        cnt_q, cur_idx;
  logic [DATA_BITS-1:0] data_q;
  logic [CHK_BITS-1:0]  rx_q, crc;
  logic                 take, in_data;
  logic [DIW-1:0]       wr_pos;

  always_comb begin
    cur_idx = blk_start_i ? '0 : cnt_q;
    take    = bit_vld_i && (blk_start_i || active_q) && !clr_i;
    in_data = cur_idx < CW'(DATA_BITS);
    // payload bytes arrive MSB first: mirror the bit index inside the byte
    wr_pos  = DIW'({cur_idx[CW-1:3], ~cur_idx[2:0]});
  end

  subq_crc16 #(.W(CHK_BITS), .POLY(subq_pkg::CHK_POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (take && blk_start_i),
    .en_i   (take && in_data),
    .bit_i  (bit_i),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      data_q   <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (take) begin
        active_q <= 1'b1;
        cnt_q    <= cur_idx + 1'b1;
        if (in_data) data_q[wr_pos] <= bit_i;
        else         rx_q <= {rx_q[CHK_BITS-2:0], bit_i};
        if (cur_idx == CW'(TOTAL - 1)) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          done_q   <= 1'b1;
          pass_q   <= ({rx_q[CHK_BITS-2:0], bit_i} == ~crc);
        end
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign data_o = data_q;

  a_r1_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TOTAL));
  a_r1_done_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(bit_vld_i));
endmodule

// File: rtl/subq_id_detect.sv
module subq_id_detect (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       frame_stb_i,
  input  logic       user_l_i,
  input  logic       user_r_i,
  input  logic [7:0] cat_code_i,
  output logic       start_o,
  output logic       short_o
);
  logic armed_q, start_q, short_q, dat;

  assign dat = (cat_code_i[7:1] == subq_pkg::DAT_CAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      start_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      short_q <= 1'b0;
      if (clr_i) begin
        armed_q <= 1'b0;
      end else if (frame_stb_i) begin
        if (!dat) begin
          armed_q <= 1'b0;
        end else if (armed_q) begin
          short_q <= user_l_i;
          armed_q <= 1'b0;
        end else if (user_l_i) begin
          if (user_r_i) start_q <= 1'b1;
          else          armed_q <= 1'b1;
        end
      end
    end
  end

  assign start_o = start_q;
  assign short_o = short_q;

  a_r4_dat_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q || short_q) |-> $past(cat_code_i[7:1] == subq_pkg::DAT_CAT && frame_stb_i));
  a_r5_r6_one_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_q, short_q}));
endmodule

// File: rtl/subq_strobe.sv
module subq_strobe #(
  parameter int unsigned PULSE_FRAMES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  input  logic frame_stb_i,
  output logic rdy_no_o
);
  localparam int unsigned PW = $clog2(PULSE_FRAMES + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       left_q <= '0;
    else if (clr_i)                    left_q <= '0;
    else if (trig_i)                   left_q <= PW'(PULSE_FRAMES);
    else if (frame_stb_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign rdy_no_o = (left_q == '0);

  a_r7_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no_o && !frame_stb_i && !clr_i) |=> !rdy_no_o);
  a_r7_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_no_o) |-> $past(frame_stb_i || clr_i));
endmodule

// File: rtl/subq_capture.sv
module subq_capture #(
  parameter int unsigned DATA_BITS    = subq_pkg::Q_DATA_BITS,
  parameter int unsigned CHK_BITS     = subq_pkg::Q_CHK_BITS,
  parameter int unsigned PULSE_FRAMES = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lock_err_i,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  input  logic                 blk_start_i,
  input  logic                 frame_stb_i,
  input  logic                 user_l_i,
  input  logic                 user_r_i,
  input  logic [7:0]           cat_code_i,
  output logic [DATA_BITS-1:0] q_data_o,
  output logic                 q_flag_o,
  output logic                 rdy_no_o
);
  logic                 col_done, col_pass, id_start, id_short, trig;
  logic [DATA_BITS-1:0] col_data, buf_q;
  logic                 flag_q;

  subq_collect #(.DATA_BITS(DATA_BITS), .CHK_BITS(CHK_BITS)) u_collect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (lock_err_i),
    .bit_vld_i   (bit_vld_i),
    .bit_i       (bit_i),
    .blk_start_i (blk_start_i),
    .done_o      (col_done),
    .pass_o      (col_pass),
    .data_o      (col_data)
  );

  subq_id_detect u_id (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (lock_err_i),
    .frame_stb_i (frame_stb_i),
    .user_l_i    (user_l_i),
    .user_r_i    (user_r_i),
    .cat_code_i  (cat_code_i),
    .start_o     (id_start),
    .short_o     (id_short)
  );

  assign trig = !lock_err_i && (col_done || id_start || id_short);

  subq_strobe #(.PULSE_FRAMES(PULSE_FRAMES)) u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (lock_err_i),
    .trig_i      (trig),
    .frame_stb_i (frame_stb_i),
    .rdy_no_o    (rdy_no_o)
  );

  // marker results take priority over a block completing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      flag_q <= 1'b0;
    end else if (!lock_err_i) begin
      if (id_start) begin
        buf_q  <= '1;
        flag_q <= 1'b1;
      end else if (id_short) begin
        buf_q  <= '0;
        flag_q <= 1'b0;
      end else if (col_done) begin
        buf_q  <= col_data;
        flag_q <= col_pass;
      end
    end
  end

  assign q_data_o = lock_err_i ? '0 : buf_q;
  assign q_flag_o = lock_err_i ? 1'b0 : flag_q;

  a_r1_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no_o) |-> $past(col_done || id_start || id_short));
  a_r8_lock_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_err_i) |-> rdy_no_o);
endmodule

// File: tb/subq_capture_bench.sv
`timescale 1ns/1ps
module subq_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_err = 1'b0, bit_vld = 1'b0, bit_d = 1'b0, blk_start = 1'b0;
  logic        frame_stb = 1'b0, ul = 1'b0, ur = 1'b0;
  logic [7:0]  cat = 8'h00;
  logic [79:0] q_data;
  logic        q_flag, rdy_n;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  subq_capture u_subq_capture (
    .clk_i(clk), .rst_ni(rst_n), .lock_err_i(lock_err), .bit_vld_i(bit_vld),
    .bit_i(bit_d), .blk_start_i(blk_start), .frame_stb_i(frame_stb),
    .user_l_i(ul), .user_r_i(ur), .cat_code_i(cat),
    .q_data_o(q_data), .q_flag_o(q_flag), .rdy_no_o(rdy_n)
  );

  task automatic check(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] calc_crc(logic [79:0] d);
    logic [15:0] c = '0;
    for (int b = 0; b < 10; b++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = d[8*b+i] ^ c[15];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
      end
    return c;
  endfunction

  function automatic logic get_bit(logic [79:0] d, logic [15:0] chk, int n);
    if (n < 80) return d[8*(n/8) + 7 - (n%8)];
    return chk[15 - (n-80)];
  endfunction

  task automatic send_bit(logic b, logic first);
    @(negedge clk);
    bit_vld = 1'b1; bit_d = b; blk_start = first;
    @(negedge clk);
    bit_vld = 1'b0; blk_start = 1'b0;
  endtask

  task automatic send_range(logic [79:0] d, logic [15:0] chk, int from, int upto);
    for (int n = from; n < upto; n++) send_bit(get_bit(d, chk, n), n == 0);
  endtask

  task automatic frame(logic l, logic r);
    @(negedge clk);
    frame_stb = 1'b1; ul = l; ur = r;
    @(negedge clk);
    frame_stb = 1'b0; ul = 1'b0; ur = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // counts frames until ready returns high; expects exactly 6
  task automatic check_pulse_width(string req);
    int n = 0;
    check({req, " strobe low"}, {79'b0, rdy_n}, 80'd0);
    for (int k = 0; k < 8 && rdy_n === 1'b0; k++) begin
      frame(1'b0, 1'b0);
      n++;
    end
    check({req, " pulse frames"}, 80'(n), 80'd6);
  endtask

  task automatic t_reset();
    check("R9 rdy", {79'b0, rdy_n}, 80'd1);
    check("R9 data", q_data, 80'd0);
    check("R9 flag", {79'b0, q_flag}, 80'd0);
  endtask

  task automatic t_good_block(logic [79:0] d);
    logic [15:0] chk = ~calc_crc(d);
    send_range(d, chk, 0, 95);
    settle();
    check("R1 no strobe before bit 96", {79'b0, rdy_n}, 80'd1);
    send_range(d, chk, 95, 96);
    settle();
    check("R3 payload order", q_data, d);
    check("R2 pass flag", {79'b0, q_flag}, 80'd1);
    check_pulse_width("R7");
  endtask

  task automatic t_bad_block(logic [79:0] d);
    logic [15:0] chk = ~calc_crc(d) ^ 16'h0100;
    send_range(d, chk, 0, 96);
    settle();
    check("R2 fail flag", {79'b0, q_flag}, 80'd0);
    check("R2 data on fail", q_data, d);
    check_pulse_width("R7 fail block");
  endtask

  task automatic t_restart(logic [79:0] junk, logic [79:0] d);
    send_range(junk, 16'h0, 0, 40);
    send_range(d, ~calc_crc(d), 0, 96);
    settle();
    check("R1 restart data", q_data, d);
    check("R1 restart flag", {79'b0, q_flag}, 80'd1);
    check_pulse_width("R1 restart");
  endtask

  task automatic t_non_dat(logic [79:0] held);
    cat = 8'h41;
    frame(1'b1, 1'b1);
    settle();
    check("R4 no start when not DAT", {79'b0, rdy_n}, 80'd1);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b0);
    settle();
    check("R4 no short when not DAT", {79'b0, rdy_n}, 80'd1);
    check("R4 buffer kept", q_data, held);
  endtask

  task automatic t_start_id();
    cat = 8'b1100_0001;
    frame(1'b1, 1'b1);
    settle();
    check("R5 all ones", q_data, '1);
    check("R5 flag", {79'b0, q_flag}, 80'd1);
    check_pulse_width("R5");
  endtask

  task automatic t_short_id();
    cat = 8'b1100_0000;
    frame(1'b1, 1'b0);
    settle();
    check("R6 armed only", {79'b0, rdy_n}, 80'd1);
    frame(1'b1, 1'b0);
    settle();
    check("R6 all zeros", q_data, '0);
    check("R6 flag", {79'b0, q_flag}, 80'd0);
    check_pulse_width("R6");
  endtask

  task automatic t_lock(logic [79:0] d, logic [79:0] d2);
    logic [15:0] chk = ~calc_crc(d);
    send_range(d, chk, 0, 96);
    settle();
    check("R8 setup", q_data, d);
    @(negedge clk) lock_err = 1'b1;
    @(negedge clk);
    check("R8 strobe ended", {79'b0, rdy_n}, 80'd1);
    check("R8 data forced", q_data, 80'd0);
    check("R8 flag forced", {79'b0, q_flag}, 80'd0);
    @(negedge clk) lock_err = 1'b0;
    send_range(d2, ~calc_crc(d2), 0, 50);
    @(negedge clk) lock_err = 1'b1;
    @(negedge clk) lock_err = 1'b0;
    send_range(d2, ~calc_crc(d2), 50, 96);
    settle();
    check("R8 partial discarded", {79'b0, rdy_n}, 80'd1);
    check("R8 buffer restored", q_data, d);
    check("R1 stray bits ignored flag", {79'b0, q_flag}, 80'd1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_block(80'h0123_4567_89AB_CDEF_F00D);
    t_good_block(80'h8000_0000_0000_0000_0001);
    t_bad_block(80'h5A5A_1234_0000_FFFF_C3C3);
    t_restart(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 80'hDEAD_BEEF_CAFE_0102_0304);
    t_non_dat(80'hDEAD_BEEF_CAFE_0102_0304);
    t_start_id();
    t_short_id();
    t_lock(80'h1111_2222_3333_4444_5555, 80'h9999_8888_7777_6666_AAAA);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule